// File: doc/BRIEF.md
# Four-Phase Pulse Slot Multiplexer

The block merges three channel event streams and a frame marker onto one serial line. A free-running tick counter divides the system clock into frames of `FRAME_TICKS` ticks. Each frame is cut into four equal slots. Slot 0 always carries a short sync pulse. Slots 1 to 3 each belong to one channel, and carry a wider data pulse when that channel's event was accepted for the frame. All slot pulses are OR-ed onto `mux_line_o`. A receiver tells the sync pulse from data by its width, and finds each channel by its position after the sync.

Each channel raises a request strobe and holds it for about one frame. The block samples the strobes once, at the edge that starts a frame. A channel may send at most one event every other frame. If a request is seen at two frame starts in a row, only the first is accepted, and a sticky per-channel overrun flag is set. `frame_start_o` is high during the first tick of each frame, so a local consumer can align to the frame.

Top module: `pulse_slot_mux`

## Requirements
- R1: After reset is released, `frame_start_o` is high for exactly one tick in every 16 ticks. The tick in which it is high is tick 0 of a frame.
- R2: In every frame, `mux_line_o` is low in tick 0, high in tick 1, and low in ticks 2 and 3. This holds whatever the requests are.
- R3: Channel c (bit c of `chan_req_i`, c = 0..2) owns slot c+1. When its request was accepted for a frame, the line is high in ticks 4(c+1), 4(c+1)+1 and 4(c+1)+2 of that frame. When it was not accepted, the line stays low through that whole slot.
- R4: The last tick of every slot (ticks 3, 7, 11 and 15) is always low, so adjacent pulses never merge.
- R5: When several channels are accepted in the same frame, all of their data pulses appear together on the single line.
- R6: Requests are sampled only at the edge that starts a frame. A change on `chan_req_i` during a frame does not alter that frame's output. Only the value present at the next frame start counts.
- R7: A request seen at a frame start right after a frame in which the same channel was accepted is rejected: no pulse is sent for it. That channel's bit in `overrun_o` is then set, and it stays set until reset. `overrun_o` changes only in the tick where `frame_start_o` is high.
- R8: While reset is asserted, all outputs are low. After release, `mux_line_o` stays low until the first frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, one tick per cycle |
| rst_ni | input | 1 | Asynchronous reset, active low |
| chan_req_i | input | NUM_CH | Per-channel event request, sampled at frame start |
| mux_line_o | output | 1 | OR of the sync pulse and all data pulses |
| frame_start_o | output | 1 | High during tick 0 of each frame |
| overrun_o | output | NUM_CH | Sticky flag per channel for rejected back-to-back requests |

## Verification
The checker makes no assumption about how the requests behave. It tracks the frame position with its own tick counter, which starts at the first `frame_start_o`. From that count it derives the sync and gap windows. So its only assumption is that `chan_req_i` is synchronous to `clk_i`. The stimulus changes requests only on falling edges. Some requests are deliberately repeated in consecutive frames to provoke overruns, and some are changed in mid-frame. This checks that only the value present at frame start is used.

// File: rtl/psm_pkg.sv
`timescale 1ns/1ps
package psm_pkg;
  // true when tick t lies in [start, start+len)
  function automatic logic in_window(int unsigned t, int unsigned start, int unsigned len);
    return (t >= start) && (t < start + len);
  endfunction
endpackage

// File: rtl/psm_timebase.sv
`timescale 1ns/1ps
module psm_timebase #(
  parameter int unsigned FRAME_TICKS = 16,
  localparam int unsigned CW = $clog2(FRAME_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [CW-1:0] tick_o,
  output logic          run_o,
  output logic          frame_adv_o
);
  localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);

  logic [CW-1:0] tick_q;
  logic          run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tick_q <= '0;
      run_q  <= 1'b0;
    end else if (!run_q) begin
      run_q  <= 1'b1;
    end else begin
      tick_q <= (tick_q == LAST) ? '0 : tick_q + 1'b1;
    end
  end

  assign tick_o      = tick_q;
  assign run_o       = run_q;
  // edge that enters tick 0 of a frame
  assign frame_adv_o = !run_q || (tick_q == LAST);
endmodule

// File: rtl/psm_req_gate.sv
`timescale 1ns/1ps
module psm_req_gate #(
  parameter int unsigned NUM_CH = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_adv_i,
  input  logic [NUM_CH-1:0] req_i,
  output logic [NUM_CH-1:0] act_o,
  output logic [NUM_CH-1:0] ovr_o
);
  logic [NUM_CH-1:0] act_q, ovr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
      ovr_q <= '0;
    end else if (frame_adv_i) begin
      // back-to-back request: drop it and flag
      act_q <= req_i & ~act_q;
      ovr_q <= ovr_q | (req_i & act_q);
    end
  end

  assign act_o = act_q;
  assign ovr_o = ovr_q;
endmodule

// File: rtl/psm_slot_shaper.sv
`timescale 1ns/1ps
module psm_slot_shaper
  import psm_pkg::*;
#(
  parameter int unsigned FRAME_TICKS = 16,
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned DATA_TICKS  = 3,
  parameter int unsigned SYNC_DLY    = 1,
  parameter int unsigned SYNC_TICKS  = 1,
  localparam int unsigned CW   = $clog2(FRAME_TICKS),
  localparam int unsigned SLOT = FRAME_TICKS / (NUM_CH + 1)
) (
  input  logic [CW-1:0]     tick_i,
  input  logic              run_i,
  input  logic [NUM_CH-1:0] act_i,
  output logic              line_o
);
  logic [NUM_CH-1:0] data_hit;
  logic              sync_hit;

  assign sync_hit = in_window(32'(tick_i), SYNC_DLY, SYNC_TICKS);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    localparam int unsigned START = (c + 1) * SLOT;
    assign data_hit[c] = act_i[c] && in_window(32'(tick_i), START, DATA_TICKS);
  end

  assign line_o = run_i && (sync_hit || (|data_hit));
endmodule

// File: rtl/pulse_slot_mux.sv
`timescale 1ns/1ps
module pulse_slot_mux #(
  parameter int unsigned FRAME_TICKS = 16,
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned DATA_TICKS  = 3,
  parameter int unsigned SYNC_DLY    = 1,
  parameter int unsigned SYNC_TICKS  = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_CH-1:0] chan_req_i,
  output logic              mux_line_o,
  output logic              frame_start_o,
  output logic [NUM_CH-1:0] overrun_o
);
  localparam int unsigned CW = $clog2(FRAME_TICKS);

  logic [CW-1:0]     tick;
  logic              run, frame_adv;
  logic [NUM_CH-1:0] act;

  psm_timebase #(.FRAME_TICKS(FRAME_TICKS)) u_tb (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_o     (tick),
    .run_o      (run),
    .frame_adv_o(frame_adv)
  );

  psm_req_gate #(.NUM_CH(NUM_CH)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_adv_i(frame_adv),
    .req_i      (chan_req_i),
    .act_o      (act),
    .ovr_o      (overrun_o)
  );

  psm_slot_shaper #(
    .FRAME_TICKS(FRAME_TICKS),
    .NUM_CH     (NUM_CH),
    .DATA_TICKS (DATA_TICKS),
    .SYNC_DLY   (SYNC_DLY),
    .SYNC_TICKS (SYNC_TICKS)
  ) u_shape (
    .tick_i(tick),
    .run_i (run),
    .act_i (act),
    .line_o(mux_line_o)
  );

  assign frame_start_o = run && (tick == '0);
endmodule

// File: rtl/psm_checker.sv
`timescale 1ns/1ps
module psm_checker #(
  parameter int unsigned FRAME_TICKS = 16,
  parameter int unsigned NUM_CH      = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] chan_req_i,
  input logic              mux_line_o,
  input logic              frame_start_o,
  input logic [NUM_CH-1:0] overrun_o
);
  localparam int unsigned CW   = $clog2(FRAME_TICKS);
  localparam int unsigned SLOT = FRAME_TICKS / (NUM_CH + 1);
  localparam logic [CW-1:0] LAST = CW'(FRAME_TICKS - 1);

  logic          seen_q;
  logic [CW-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      pos_q  <= '0;
    end else if (frame_start_o) begin
      seen_q <= 1'b1;
      pos_q  <= '0;
    end else begin
      pos_q  <= pos_q + 1'b1;
    end
  end

  p_period_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && pos_q == LAST) |-> frame_start_o);
  p_no_early_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && frame_start_o) |-> pos_q == LAST);
  p_sync_high_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |=> mux_line_o);
  p_sync_narrow_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(frame_start_o, 2) |-> !mux_line_o);
  p_slot_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seen_q && !frame_start_o && ((32'(pos_q) + 1) % SLOT == SLOT - 1)) |-> !mux_line_o);
  p_ovr_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(overrun_o) & ~overrun_o) == '0);
  p_ovr_at_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (overrun_o != $past(overrun_o)) |-> frame_start_o);
  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!seen_q && !frame_start_o) |-> !mux_line_o);

  logic unused_req;
  assign unused_req = ^chan_req_i;
endmodule

bind pulse_slot_mux psm_checker #(.FRAME_TICKS(FRAME_TICKS), .NUM_CH(NUM_CH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .chan_req_i   (chan_req_i),
  .mux_line_o   (mux_line_o),
  .frame_start_o(frame_start_o),
  .overrun_o    (overrun_o)
);

// File: tb/pulse_slot_mux_bench.sv
`timescale 1ns/1ps
module pulse_slot_mux_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] chan_req_i = '0;
  logic       mux_line_o, frame_start_o;
  logic [2:0] overrun_o;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [15:0] pat;
    logic [2:0]  acc;
    logic [2:0]  ovr;
    logic        mid;
  } item_t;

  item_t q[$];
  logic [2:0] m_act = '0;
  logic [2:0] m_ovr = '0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pulse_slot_mux u_pulse_slot_mux (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .chan_req_i   (chan_req_i),
    .mux_line_o   (mux_line_o),
    .frame_start_o(frame_start_o),
    .overrun_o    (overrun_o)
  );

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_pat(logic [2:0] acc);
    logic [15:0] p = 16'h0002;
    for (int c = 0; c < 3; c++)
      if (acc[c]) for (int j = 0; j < 3; j++) p[4*(c+1)+j] = 1'b1;
    return p;
  endfunction

  function automatic item_t model(logic [2:0] r, logic mid);
    item_t it;
    logic [2:0] acc = r & ~m_act;
    m_ovr = m_ovr | (r & m_act);
    m_act = acc;
    it.pat = exp_pat(acc);
    it.acc = acc;
    it.ovr = m_ovr;
    it.mid = mid;
    return it;
  endfunction

  // driver: at frame start set the request for the next frame
  task automatic drive_frame(logic [2:0] first, logic [2:0] final_v, logic mid);
    do @(negedge clk_i); while (!frame_start_o);
    chan_req_i = first;
    if (mid) begin
      repeat (8) @(negedge clk_i);
      chan_req_i = final_v;
    end
    q.push_back(model(final_v, mid));
  endtask

  // monitor
  initial begin
    logic [15:0] pat, fr;
    logic [2:0]  ovr;
    item_t it;
    forever begin
      @(negedge clk_i);
      if (rst_ni && frame_start_o) begin
        pat[0] = mux_line_o; fr[0] = frame_start_o; ovr = overrun_o;
        for (int i = 1; i < 16; i++) begin
          @(negedge clk_i);
          pat[i] = mux_line_o; fr[i] = frame_start_o;
        end
        if (q.size() > 0) begin
          it = q.pop_front();
          chk("R1 frame_start", fr, 16'h0001);
          chk("R2 sync slot", {12'h0, pat[3:0]}, {12'h0, it.pat[3:0]});
          if ($countones(it.acc) > 1)
            chk("R5 combined slots", {4'h0, pat[15:4]}, {4'h0, it.pat[15:4]});
          else
            chk("R3 channel slots", {4'h0, pat[15:4]}, {4'h0, it.pat[15:4]});
          if (it.mid)
            chk("R6 mid-frame change", pat, it.pat);
          chk("R4 slot gaps", {12'h0, pat[15], pat[11], pat[7], pat[3]}, 16'h0);
          chk("R7 overrun", {13'h0, ovr}, {13'h0, it.ovr});
        end
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R8 reset state
    chk("R8 reset line", {15'h0, mux_line_o}, 16'h0);
    chk("R8 reset frame", {15'h0, frame_start_o}, 16'h0);
    chk("R8 reset overrun", {13'h0, overrun_o}, 16'h0);
    q.push_back(model(3'b000, 1'b0));
    rst_ni = 1'b1;
    drive_frame(3'b001, 3'b001, 0);
    drive_frame(3'b000, 3'b000, 0);
    drive_frame(3'b010, 3'b010, 0);
    drive_frame(3'b100, 3'b100, 0);
    drive_frame(3'b111, 3'b111, 0);  // R5
    drive_frame(3'b000, 3'b000, 0);
    drive_frame(3'b011, 3'b100, 1);  // R6
    drive_frame(3'b100, 3'b100, 0);  // R7 back-to-back
    drive_frame(3'b100, 3'b100, 0);
    drive_frame(3'b000, 3'b000, 0);
    drive_frame(3'b000, 3'b101, 1);  // R6
    drive_frame(3'b101, 3'b101, 0);  // R7
    drive_frame(3'b000, 3'b000, 0);
    drive_frame(3'b010, 3'b010, 0);
    drive_frame(3'b010, 3'b010, 0);  // R7
    drive_frame(3'b000, 3'b000, 0);
    while (q.size() > 0) @(negedge clk_i);
    repeat (2) @(negedge clk_i);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule